// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO

This block moves 36-bit words from a producer running on one clock to a consumer running on an unrelated clock. Storage depth is a parameter (512, 1024 or 2048 words). The producer sees `in_ready`, which says that a free location exists. The consumer sees `out_ready`, which says that a fresh word is already waiting in the output register. The consumer never has to issue a request to fetch the head word. It reads `rd_data` while `out_ready` is high and pulses `rd_en` to take it.

Both pointers carry one bit beyond the address width. Each pointer is passed to the other clock domain in Gray code through a chain of flip-flops. Because of this chain, each ready flag responds to activity on the far port after a fixed number of local clock edges.

- On the read side, a word written into an empty FIFO reaches the output register on the third read-clock edge after the write.
- On the write side, a location freed by the reader is seen on the second write-clock edge after it is freed.

The reset input `rst` is synchronous and active high. It must be held for several edges of both clocks.

Top module: `dcfifo_fwft`

## Requirements
- R1: While `rst` is high, `in_ready` and `out_ready` are low and `rd_data` is zero. After `rst` falls, `in_ready` stays low after the first write-clock edge and is high after the second.
- R2: A word is accepted at a write-clock edge only when `wr_en` and `in_ready` are both high. A word offered while `in_ready` is low is discarded and never appears at `rd_data`.
- R3: With no reads, exactly DEPTH+1 words are accepted before `in_ready` goes low: DEPTH words in memory plus one in the output register.
- R4: A word written into an empty FIFO appears on `rd_data`, with `out_ready` rising, on the third read-clock edge after the write edge. `out_ready` is still low after the first and second such edges.
- R5: A read-clock edge with `rd_en` and `out_ready` high consumes the held word. If another word is visible to the read side, that word loads on the same edge and `out_ready` stays high. Otherwise `out_ready` falls.
- R6: `rd_en` while `out_ready` is low has no effect: `rd_data` keeps the previously delivered word.
- R7: From full, after a read-clock edge moves a word out of memory, `in_ready` is still low after the first write-clock edge and high after the second. A write in the following cycle is accepted.
- R8: Under independent, irregular enable patterns on both ports, words come out in write order with none lost or duplicated. Each pointer crossing changes at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rst | input | 1 | Synchronous active-high reset, applied in both domains |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Word to store |
| in_ready | output | 1 | A free location exists (write-clock domain) |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Take the word held in the output register |
| rd_data | output | 36 | Output register contents |
| out_ready | output | 1 | Output register holds an unread word (read-clock domain) |

## Verification
The hardest state to reach from the ports is the exact edge on which a cross-domain pointer change becomes visible, most of all the release from full. That case needs the memory brimming, one word pulled out, and then the write-clock edges counted one by one.

The two clocks run at periods of 4 ns and 6 ns with an offset, so their edges never coincide and every edge count is unambiguous. Directed sequences first fill the FIFO with the reader idle, then drain it a single word at a time. Seeded random enables on both ports follow, with a scoreboard checking the order of delivered words.

// File: rtl/fwft_pkg.sv
package fwft_pkg;

    localparam int unsigned WORD_W = 36;

    typedef logic [WORD_W-1:0] word_t;

    // Output stage of the read side: a word plus a flag saying it is unread.
    typedef struct packed {
        logic  fresh;
        word_t data;
    } out_stage_t;

    // Write-side wake-up sequence after reset.
    typedef enum logic [1:0] {
        WAKE_HELD  = 2'b00,
        WAKE_ONE   = 2'b01,
        WAKE_READY = 2'b11
    } wake_t;

endpackage

// File: rtl/fwft_ram.sv
module fwft_ram
    import fwft_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);

    word_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/fwft_ptr_cross.sv
module fwft_ptr_cross #(
    parameter int unsigned W      = 10,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);

    logic [STAGES-1:0][W-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
        end else begin
            stage[0] <= gray_in;
            for (int s = 1; s < STAGES; s++) begin
                stage[s] <= stage[s-1];
            end
        end
    end

    // Gray to binary: each bit is the parity of all bits at or above it.
    for (genvar b = 0; b < W; b++) begin : g_g2b
        assign bin_out[b] = ^stage[STAGES-1][W-1:b];
    end

endmodule

// File: rtl/fwft_wr_side.sv
module fwft_wr_side
    import fwft_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] rbin_seen,
    output logic [PW-1:0] wgray,
    output logic [AW-1:0] waddr,
    output logic          we,
    output logic          in_ready
);

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nx;
    logic [PW-1:0] fill;
    logic          full;
    wake_t         wake;

    assign fill     = wbin - rbin_seen;
    assign full     = (fill == PW'(DEPTH));
    assign in_ready = (wake == WAKE_READY) && !full;
    assign we       = wr_en && in_ready;
    assign waddr    = wbin[AW-1:0];
    assign wbin_nx  = wbin + PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
            wake  <= WAKE_HELD;
        end else begin
            wake <= (wake == WAKE_HELD) ? WAKE_ONE : WAKE_READY;
            if (we) begin
                wbin  <= wbin_nx;
                wgray <= wbin_nx ^ (wbin_nx >> 1);
            end
        end
    end

    assert_gray_onestep_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        fill <= PW'(DEPTH));

    assert_wake_delay_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !in_ready);

endmodule

// File: rtl/fwft_rd_side.sv
module fwft_rd_side
    import fwft_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [PW-1:0] wbin_seen,
    input  word_t         mem_word,
    output logic [PW-1:0] rgray,
    output logic [AW-1:0] raddr,
    output word_t         rd_data,
    output logic          out_ready
);

    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nx;
    logic          avail;
    logic          load;
    out_stage_t    ostage;

    assign avail     = (wbin_seen != rbin);
    assign load      = avail && (!ostage.fresh || rd_en);
    assign raddr     = rbin[AW-1:0];
    assign rbin_nx   = rbin + PW'(1);
    assign rd_data   = ostage.data;
    assign out_ready = ostage.fresh;

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin   <= '0;
            rgray  <= '0;
            ostage <= '0;
        end else if (load) begin
            ostage.fresh <= 1'b1;
            ostage.data  <= mem_word;
            rbin         <= rbin_nx;
            rgray        <= rbin_nx ^ (rbin_nx >> 1);
        end else if (rd_en) begin
            ostage.fresh <= 1'b0;
        end
    end

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !ostage.fresh |=> (ostage.fresh || $stable(ostage.data)));

    assert_rise_needs_data_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ostage.fresh) |-> $past(wbin_seen != rbin));

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        (wbin_seen - rbin) <= PW'(DEPTH));

    assert_rptr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (rbin != $past(rbin)) |-> (rbin == $past(rbin) + PW'(1)));

endmodule

// File: rtl/dcfifo_fwft.sv
module dcfifo_fwft
    import fwft_pkg::*;
#(
    parameter int unsigned DEPTH       = 512,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              in_ready,
    input  logic              rd_clk,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              out_ready
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;

    logic [PW-1:0] wgray, rgray;
    logic [PW-1:0] wbin_at_rd, rbin_at_wr;
    logic [AW-1:0] waddr, raddr;
    logic          we;
    word_t         mem_word;

    fwft_wr_side #(.DEPTH(DEPTH)) u_wr (
        .clk       (wr_clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rbin_seen (rbin_at_wr),
        .wgray     (wgray),
        .waddr     (waddr),
        .we        (we),
        .in_ready  (in_ready)
    );

    fwft_ram #(.DEPTH(DEPTH)) u_ram (
        .clk   (wr_clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_word)
    );

    fwft_ptr_cross #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk     (rd_clk),
        .rst     (rst),
        .gray_in (wgray),
        .bin_out (wbin_at_rd)
    );

    fwft_ptr_cross #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk     (wr_clk),
        .rst     (rst),
        .gray_in (rgray),
        .bin_out (rbin_at_wr)
    );

    fwft_rd_side #(.DEPTH(DEPTH)) u_rd (
        .clk       (rd_clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .wbin_seen (wbin_at_rd),
        .mem_word  (mem_word),
        .rgray     (rgray),
        .raddr     (raddr),
        .rd_data   (rd_data),
        .out_ready (out_ready)
    );

endmodule

// File: tb/sim_dcfifo_fwft.sv
`timescale 1ns/100ps
module sim_dcfifo_fwft;

    localparam int DEPTH = 512;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic        in_ready;
    logic        rd_en = 1'b0;
    logic [35:0] rd_data;
    logic        out_ready;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [35:0] sb [$];

    dcfifo_fwft #(.DEPTH(DEPTH)) u0 (
        .wr_clk(wr_clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .in_ready(in_ready), .rd_clk(rd_clk), .rd_en(rd_en),
        .rd_data(rd_data), .out_ready(out_ready)
    );

    initial forever #2 wr_clk = ~wr_clk;
    initial begin
        #0.5;
        forever #3 rd_clk = ~rd_clk;
    end

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_try(input bit en, input logic [35:0] d, output bit acc);
        @(negedge wr_clk);
        wr_en = en;
        wr_data = d;
        acc = en && in_ready;
        if (acc) sb.push_back(d);
        @(posedge wr_clk);
        #0.1;
        wr_en = 1'b0;
    endtask

    task automatic rd_try(input bit en);
        logic [35:0] exp;
        @(negedge rd_clk);
        rd_en = en;
        if (en && out_ready) begin
            exp = sb.pop_front();
            check(rd_data == exp, "R8 order", 64'(rd_data), 64'(exp));
        end
        @(posedge rd_clk);
        #0.1;
        rd_en = 1'b0;
    endtask

    initial begin
        bit acc;
        int n_acc;
        logic [35:0] word_a;
        void'($urandom(32'd4242));

        // R1: reset state and wake-up
        repeat (6) @(posedge rd_clk);
        #0.2;
        check(!in_ready, "R1 in_ready in reset", 64'(in_ready), 0);
        check(!out_ready, "R1 out_ready in reset", 64'(out_ready), 0);
        check(rd_data == 0, "R1 rd_data in reset", 64'(rd_data), 0);
        @(negedge wr_clk);
        rst = 1'b0;
        @(posedge wr_clk); #0.2;
        check(!in_ready, "R1 in_ready first edge", 64'(in_ready), 0);
        @(posedge wr_clk); #0.2;
        check(in_ready, "R1 in_ready second edge", 64'(in_ready), 1);
        repeat (4) @(posedge rd_clk);

        // R4: latency into the output register
        word_a = 36'h9_1234_5678;
        wr_try(1'b1, word_a, acc);
        for (int k = 1; k <= 3; k++) begin
            @(posedge rd_clk); #0.2;
            check(out_ready == (k == 3), "R4 out_ready edge count",
                  64'(out_ready), 64'(k == 3));
        end
        check(rd_data == word_a, "R4 word delivered", 64'(rd_data), 64'(word_a));
        rd_try(1'b1);
        #0.1;
        check(!out_ready, "R5 flag falls when nothing follows", 64'(out_ready), 0);

        // R6: reads while empty are ignored
        for (int k = 0; k < 5; k++) begin
            rd_try(1'b1);
            #0.1;
            check(!out_ready && rd_data == word_a, "R6 hold previous word",
                  64'(rd_data), 64'(word_a));
        end

        // R5: back-to-back reads
        wr_try(1'b1, 36'h0_AAAA_0001, acc);
        wr_try(1'b1, 36'h0_AAAA_0002, acc);
        wr_try(1'b1, 36'h0_AAAA_0003, acc);
        repeat (8) @(posedge rd_clk);
        for (int k = 0; k < 3; k++) begin
            @(negedge rd_clk);
            check(out_ready, "R5 back-to-back ready", 64'(out_ready), 1);
            rd_try(1'b1);
        end
        #0.1;
        check(!out_ready, "R5 empty after three reads", 64'(out_ready), 0);

        // R3: capacity with idle reader
        n_acc = 0;
        for (int i = 0; i < DEPTH + 24; i++) begin
            wr_try(1'b1, 36'h1_0000_0000 | 36'(i), acc);
            if (acc) n_acc++;
        end
        check(n_acc == DEPTH + 1, "R3 accepted words", 64'(n_acc), 64'(DEPTH + 1));

        // R2: a write while full is dropped
        @(negedge wr_clk);
        check(!in_ready, "R2 in_ready low when full", 64'(in_ready), 0);
        wr_try(1'b1, 36'hB_ADBA_DBAD, acc);
        check(!acc, "R2 write refused", 64'(acc), 0);

        // R7: release from full
        rd_try(1'b1);
        @(posedge wr_clk); #0.2;
        check(!in_ready, "R7 in_ready first write edge", 64'(in_ready), 0);
        @(posedge wr_clk); #0.2;
        check(in_ready, "R7 in_ready second write edge", 64'(in_ready), 1);
        wr_try(1'b1, 36'h7_7777_7777, acc);
        check(acc, "R7 write accepted after release", 64'(acc), 1);

        // Drain; the dropped word must never surface (R2 via scoreboard)
        for (int i = 0; i < 4 * DEPTH && sb.size() > 0; i++) rd_try(1'b1);
        check(sb.size() == 0, "R2 drained with no extra word", 64'(sb.size()), 0);
        repeat (6) @(posedge rd_clk); #0.2;
        check(!out_ready, "R8 empty after drain", 64'(out_ready), 0);

        // R8: random traffic on both ports
        fork
            begin
                for (int i = 0; i < 3000; i++)
                    wr_try(($urandom % 100) < 55, 36'h2_0000_0000 | 36'(i), acc);
            end
            begin
                for (int i = 0; i < 2000; i++)
                    rd_try(($urandom % 100) < 60);
            end
        join
        for (int i = 0; i < 8 * DEPTH && sb.size() > 0; i++) rd_try(1'b1);
        check(sb.size() == 0, "R8 all words delivered", 64'(sb.size()), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge wr_clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule